// File: doc/BRIEF.md
# Shared Bit-Clock / De-emphasis Pin Monitor

This block sits behind one input pin that does two jobs. A transmitter can drive a free-running serial bit clock into it, or a board can strap it to a steady level that selects the de-emphasis filter. The monitor decides which use is in effect. It counts rising pin edges inside each half of the frame clock, and it counts whole frame periods that pass without any pin edge. When the pin is used as a level, the monitor also debounces that level over successive falling frame-clock edges and produces a clean de-emphasis enable.

Both the pin and the frame clock are asynchronous to the master clock. Each passes through its own synchronizer chain, and all edge detection happens on the synchronized copies. A raw change therefore reaches the outputs on the third master-clock edge, counting the edge that first samples it. A static high-rate input from the surrounding logic forbids de-emphasis. The receiver that uses the bit clock and the filter itself lie outside this block.

Top module: `bclk_mode_monitor`

## Requirements
- R1: While reset is held, and after it is released, `ext_bclk_mode` and `deemph_en` are both 0.
- R2: `ext_bclk_mode` rises when the 16th synchronized rising edge of `shared_pin` falls inside a single frame-clock half-period. The change appears on the third clock edge after the raw 16th rise is first sampled.
- R3: Every frame-clock transition, rising or falling, restarts the pin-edge count. A pin rise seen in the same cycle as a frame-clock transition counts toward the new half-period. So 15 rises in each of two neighbouring halves do not enter external mode.
- R4: In external mode, the block returns to internal mode on the third rising frame-clock edge seen with no pin rise since the last one. This guarantees two complete frame periods without pin activity.
- R5: Any pin rise clears the idle-frame count, including a pin rise that arrives in the same cycle as a rising frame-clock edge. A pin that rises once per frame therefore keeps external mode.
- R6: In internal mode, with high-rate off, `deemph_en` turns on after the pin reads low at 5 consecutive falling frame-clock edges.
- R7: Under the same conditions, `deemph_en` turns off after the pin reads high at 5 consecutive falling frame-clock edges.
- R8: A falling frame-clock edge whose pin level agrees with the current `deemph_en` state restarts the run. Four opposing samples, one agreeing sample, then four opposing samples leave the output unchanged.
- R9: Within one cycle of `ext_bclk_mode` being 1, `deemph_en` is 0. The pin level at falling frame edges has no effect while external mode lasts.
- R10: Within one cycle of `high_rate` being 1, `deemph_en` is 0, and the pin level has no effect while `high_rate` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shared_pin | input | 1 | Raw shared pin: external bit clock or de-emphasis level |
| frame_clk | input | 1 | Raw frame (left/right) clock |
| high_rate | input | 1 | High sample-rate operation, synchronous to clk; blocks de-emphasis |
| ext_bclk_mode | output | 1 | 1 while external bit-clock mode is active |
| deemph_en | output | 1 | Debounced de-emphasis enable |

## Verification
Two things can happen in the same master-clock cycle. A pin rise can coincide with a frame-clock transition, which tests both the restart of the edge count and the clearing of the idle count. A mode change can also coincide with a pending de-emphasis run. The bench provokes the first case by changing the raw pin and the raw frame clock in the same cycle, so that both pass through equal synchronizer depth. In the idle test, the pin rises only together with rising frame edges. The bench judges both cases with a behavioural per-cycle model and with directed checks: a 15-rise half followed by a 16-rise half whose first rise sits on the frame edge must enter external mode, and the once-per-frame coincident rises must hold it.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

  // Increment that stops at a ceiling.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // True when one more opposing sample completes a run of the given length.
  function automatic logic run_done(input int unsigned run, input int unsigned len);
    return (run + 1) >= len;
  endfunction

  function automatic logic is_rise(input logic now_lvl, input logic old_lvl);
    return now_lvl & ~old_lvl;
  endfunction

  function automatic logic is_fall(input logic now_lvl, input logic old_lvl);
    return ~now_lvl & old_lvl;
  endfunction

endpackage

// File: rtl/bcm_sync.sv
module bcm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic lvl,
  output logic lvl_d
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= chain[STAGES-1];
  end

  assign lvl = chain[STAGES-1];
endmodule

// File: rtl/bcm_mode.sv
module bcm_mode
  import bcm_pkg::*;
#(
  parameter int unsigned EDGE_THRESH = 16,
  parameter int unsigned IDLE_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_rise,
  input  logic frame_rise,
  input  logic frame_fall,
  output logic ext_mode,
  output logic enter_evt,
  output logic exit_evt
);
  localparam int unsigned IDLE_LIM = IDLE_FRAMES + 1;
  localparam int unsigned ECW = $clog2(EDGE_THRESH + 1);
  localparam int unsigned ICW = $clog2(IDLE_LIM + 1);
  localparam logic [ECW-1:0] THR_V  = ECW'(EDGE_THRESH);
  localparam logic [ICW-1:0] IDLE_V = ICW'(IDLE_LIM);

  logic [ECW-1:0] ecnt, ecnt_nxt;
  logic [ICW-1:0] idle, idle_nxt;
  logic           frame_edge;

  assign frame_edge = frame_rise | frame_fall;

  always_comb begin
    if (frame_edge)    ecnt_nxt = pin_rise ? ECW'(1) : '0;
    else if (pin_rise) ecnt_nxt = ECW'(sat_inc(32'(ecnt), EDGE_THRESH));
    else               ecnt_nxt = ecnt;

    if (pin_rise)        idle_nxt = '0;
    else if (frame_rise) idle_nxt = ICW'(sat_inc(32'(idle), IDLE_LIM));
    else                 idle_nxt = idle;
  end

  assign enter_evt = pin_rise && (ecnt_nxt == THR_V);
  assign exit_evt  = ext_mode && !pin_rise && frame_rise && (idle_nxt == IDLE_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt     <= '0;
      idle     <= '0;
      ext_mode <= 1'b0;
    end else begin
      ecnt <= ecnt_nxt;
      idle <= idle_nxt;
      if (enter_evt)     ext_mode <= 1'b1;
      else if (exit_evt) ext_mode <= 1'b0;
    end
  end

  a_r2_enter_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_mode) |-> $past(pin_rise));
  a_r4_exit_on_quiet_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_mode) |-> ($past(frame_rise) && !$past(pin_rise)));
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt <= THR_V);
  a_r5_rise_clears_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise |=> (idle == '0));
endmodule

// File: rtl/bcm_deemph.sv
module bcm_deemph
  import bcm_pkg::*;
#(
  parameter int unsigned RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_lvl,
  input  logic frame_fall,
  input  logic ext_mode,
  input  logic high_rate,
  output logic deemph_en,
  output logic flip_evt
);
  localparam int unsigned RCW = $clog2(RUN_LEN + 1);

  logic [RCW-1:0] run;
  logic           forced, target, oppose, agree;

  assign forced   = ext_mode | high_rate;
  assign target   = ~pin_lvl;
  assign oppose   = frame_fall && (target != deemph_en);
  assign agree    = frame_fall && (target == deemph_en);
  assign flip_evt = !forced && oppose && run_done(32'(run), RUN_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deemph_en <= 1'b0;
      run       <= '0;
    end else if (forced) begin
      deemph_en <= 1'b0;
      run       <= '0;
    end else if (flip_evt) begin
      deemph_en <= target;
      run       <= '0;
    end else if (oppose) begin
      run <= run + RCW'(1);
    end else if (agree) begin
      run <= '0;
    end
  end

  a_r9_ext_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |=> !deemph_en);
  a_r10_high_rate_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    high_rate |=> !deemph_en);
  a_r6_on_from_low_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deemph_en) |-> ($past(frame_fall) && !$past(pin_lvl)));
  a_r7_off_from_high_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(deemph_en) && !$past(ext_mode) && !$past(high_rate)) |->
      ($past(frame_fall) && $past(pin_lvl)));
endmodule

// File: rtl/bclk_mode_monitor.sv
module bclk_mode_monitor
  import bcm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned EDGE_THRESH = 16,
  parameter int unsigned IDLE_FRAMES = 2,
  parameter int unsigned DEEMPH_RUN  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shared_pin,
  input  logic frame_clk,
  input  logic high_rate,
  output logic ext_bclk_mode,
  output logic deemph_en
);
  logic pin_lvl, pin_old, frm_lvl, frm_old;
  logic pin_rise, frame_rise, frame_fall;
  logic enter_evt, exit_evt, flip_evt;

  bcm_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d_async(shared_pin), .lvl(pin_lvl), .lvl_d(pin_old));

  bcm_sync #(.STAGES(SYNC_STAGES)) u_frm_sync (
    .clk(clk), .rst_n(rst_n), .d_async(frame_clk), .lvl(frm_lvl), .lvl_d(frm_old));

  assign pin_rise   = is_rise(pin_lvl, pin_old);
  assign frame_rise = is_rise(frm_lvl, frm_old);
  assign frame_fall = is_fall(frm_lvl, frm_old);

  bcm_mode #(.EDGE_THRESH(EDGE_THRESH), .IDLE_FRAMES(IDLE_FRAMES)) u_mode (
    .clk(clk), .rst_n(rst_n), .pin_rise(pin_rise), .frame_rise(frame_rise),
    .frame_fall(frame_fall), .ext_mode(ext_bclk_mode),
    .enter_evt(enter_evt), .exit_evt(exit_evt));

  bcm_deemph #(.RUN_LEN(DEEMPH_RUN)) u_deemph (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .frame_fall(frame_fall),
    .ext_mode(ext_bclk_mode), .high_rate(high_rate),
    .deemph_en(deemph_en), .flip_evt(flip_evt));

  a_r9_no_flip_in_ext: assert property (@(posedge clk) disable iff (!rst_n)
    ext_bclk_mode |-> !flip_evt);
  a_r2_mode_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(enter_evt && exit_evt));
endmodule

// File: tb/bclk_mode_monitor_bench.sv
module bclk_mode_monitor_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic shared_pin = 1'b0, frame_clk = 1'b0, high_rate = 1'b0;
  logic ext_bclk_mode, deemph_en;
  int total = 0, bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  bclk_mode_monitor u_bclk_mode_monitor (
    .clk(clk), .rst_n(rst_n), .shared_pin(shared_pin), .frame_clk(frame_clk),
    .high_rate(high_rate), .ext_bclk_mode(ext_bclk_mode), .deemph_en(deemph_en));

  // Behavioural reference: inputs captured at each clock edge, evaluated at the negedge.
  bit c_p, c_f, c_h, c_r;
  bit m_s1, m_s2, m_pv, m_f1, m_f2, m_fpv, m_ext, m_deem;
  int m_ecnt, m_idle, m_run;

  always @(posedge clk) begin
    c_p = shared_pin; c_f = frame_clk; c_h = high_rate; c_r = rst_n;
  end

  always @(negedge clk) begin
    bit pr, frr, ffl, old_ext, want;
    if (!c_r) begin
      m_s1 = 0; m_s2 = 0; m_pv = 0; m_f1 = 0; m_f2 = 0; m_fpv = 0;
      m_ext = 0; m_deem = 0; m_ecnt = 0; m_idle = 0; m_run = 0;
    end else begin
      pr  = m_s2 && !m_pv;
      frr = m_f2 && !m_fpv;
      ffl = !m_f2 && m_fpv;
      old_ext = m_ext;
      if (frr || ffl) m_ecnt = pr ? 1 : 0;
      else if (pr && m_ecnt < 16) m_ecnt++;
      if (pr && m_ecnt == 16) m_ext = 1;
      if (pr) m_idle = 0;
      else if (frr && m_idle < 3) m_idle++;
      if (old_ext && !pr && frr && m_idle == 3) m_ext = 0;
      if (old_ext || c_h) begin
        m_deem = 0; m_run = 0;
      end else if (ffl) begin
        want = !m_s2;
        if (want == m_deem) m_run = 0;
        else begin
          m_run++;
          if (m_run == 5) begin m_deem = want; m_run = 0; end
        end
      end
      m_pv = m_s2; m_s2 = m_s1; m_s1 = c_p;
      m_fpv = m_f2; m_f2 = m_f1; m_f1 = c_f;
    end
    total += 2;
    if (ext_bclk_mode !== m_ext) begin
      bad++;
      $display("FAIL model ext (R2 R3 R4 R5) t=%0t got=%0b exp=%0b", $time, ext_bclk_mode, m_ext);
    end
    if (deemph_en !== m_deem) begin
      bad++;
      $display("FAIL model deemph (R6 R7 R8 R9 R10) t=%0t got=%0b exp=%0b", $time, deemph_en, m_deem);
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic drive(input bit p, input bit f);
    @(posedge clk); #2;
    shared_pin = p; frame_clk = f;
  endtask

  // One frame-clock half: frame toggles at i=0, pin rises at off, off+2, ...
  task automatic phase(input int len, input int rises, input int off);
    bit nf, p;
    nf = ~frame_clk;
    for (int i = 0; i < len; i++) begin
      p = (i >= off) && (i < off + 2 * rises) && (((i - off) % 2) == 0);
      drive(p, nf);
    end
  endtask

  // One full frame with a static pin level: rising half, then falling half.
  task automatic frame_full(input bit lvl);
    for (int i = 0; i < 8; i++) drive(lvl, 1'b1);
    for (int i = 0; i < 8; i++) drive(lvl, 1'b0);
  endtask

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog expired (R1) got=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) drive(0, 0);
    chk("R1 ext in reset", ext_bclk_mode, 1'b0);
    chk("R1 deemph in reset", deemph_en, 1'b0);
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (3) drive(0, 0);
    chk("R1 ext after reset", ext_bclk_mode, 1'b0);

    // De-emphasis on after five low falls
    repeat (4) frame_full(0);
    chk("R6 four low falls not enough", deemph_en, 1'b0);
    frame_full(0);
    chk("R6 five low falls", deemph_en, 1'b1);

    // Broken run of high samples keeps it on, full run turns it off
    repeat (4) frame_full(1);
    frame_full(0);
    repeat (4) frame_full(1);
    chk("R8 interrupted run", deemph_en, 1'b1);
    frame_full(1);
    chk("R7 five high falls", deemph_en, 1'b0);
    repeat (5) frame_full(0);
    chk("R6 on again", deemph_en, 1'b1);

    // 15 rises per half never enter; coincident rise counts in new half
    phase(40, 15, 1);
    phase(40, 15, 1);
    chk("R3 fifteen per half", ext_bclk_mode, 1'b0);
    phase(40, 15, 1);
    phase(40, 16, 0);
    chk("R2 sixteen rises enter", ext_bclk_mode, 1'b1);
    chk("R9 deemph forced off", deemph_en, 1'b0);

    // Pin low at falling frame edges while external: ignored
    repeat (10) phase(40, 16, 1);
    chk("R9 level ignored in ext", deemph_en, 1'b0);
    chk("R2 stays ext with traffic", ext_bclk_mode, 1'b1);

    // Quiet pin: exit on the third rising frame edge
    repeat (4) phase(40, 0, 0);
    chk("R4 two quiet rises keep ext", ext_bclk_mode, 1'b1);
    repeat (2) phase(40, 0, 0);
    chk("R4 exit after two quiet frames", ext_bclk_mode, 1'b0);

    // Rises only together with rising frame edges hold external mode
    repeat (2) phase(40, 16, 1);
    chk("R2 re-enter", ext_bclk_mode, 1'b1);
    for (int k = 0; k < 4; k++) begin
      phase(40, 1, 0);
      phase(40, 0, 0);
    end
    chk("R5 coincident rises hold ext", ext_bclk_mode, 1'b1);
    repeat (6) phase(40, 0, 0);
    chk("R4 exit after coincident test", ext_bclk_mode, 1'b0);

    // High-rate blocks de-emphasis
    repeat (5) frame_full(0);
    chk("R6 on before high rate", deemph_en, 1'b1);
    @(posedge clk); #2 high_rate = 1'b1;
    drive(0, 0);
    chk("R10 high rate forces off", deemph_en, 1'b0);
    repeat (6) frame_full(0);
    chk("R10 level ignored in high rate", deemph_en, 1'b0);
    @(posedge clk); #2 high_rate = 1'b0;
    repeat (5) frame_full(0);
    chk("R6 on after high rate clears", deemph_en, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule